// File: doc/BRIEF.md
# Timer Compare Waveform Generator

This block is an 8-bit counter with two compare channels, A and B. Each channel produces a pin waveform. A three-bit waveform select input picks how the counter runs: a free-running count, clear-on-match, a single-slope PWM, or an up/down PWM. A two-bit action field per channel decides what a compare match, the top of the count or the bottom of the count does to that channel's output level. The counter only advances on cycles where the prescaled count enable is high.

Each channel either drives its waveform onto the pin or passes the ordinary port value through. The pin's output enable always follows that pin's direction bit. In both PWM families the compare values go through a holding register, and the holding register only takes a new value at the top of the count. The block also gives single-cycle pulses for counter overflow and for each compare match. The current count value is available as an output.

Top module: `tmr_cmp_wavegen`

## Requirements
- R1: After synchronous reset the count is 0, both waveforms are 0, all event pulses are 0, and the up/down direction is up.
- R2: A pin carries its channel waveform when that channel is connected, and carries its port input otherwise. Each output enable equals that pin's direction input. An action field of 00 is always disconnected.
- R3: With waveform select 000 (or a reserved code 100/110), each enabled tick adds one to the count and wraps 255 to 0. The overflow pulse rises in the cycle after the tick taken at 255.
- R4: With select 010, a tick taken while the count equals compare A returns the count to 0. Writes to either compare input take effect on the next tick. Overflow still marks the tick taken at 255.
- R5: In selects 000 and 010, a compare match on an enabled tick acts on the waveform. Field 01 toggles it, 10 drives it to 0, and 11 drives it to 1.
- R6: With select 011 the count runs from 0 to 255. With select 111 it runs from 0 to the held compare A. The tick taken at TOP returns the count to 0 and raises the overflow pulse.
- R7: In single-slope PWM, field 10 drives the waveform to 1 on the TOP tick and to 0 on a match. Field 11 does the reverse. When both happen on one tick, the TOP action wins.
- R8: With select 001 (TOP 255) or 101 (TOP held compare A), the count rises to TOP, then falls to 0, then rises again. The overflow pulse follows the tick taken at 0 while falling.
- R9: In up/down PWM, field 10 drives the waveform to 0 on a match taken while the next step goes up, and to 1 when it goes down. Field 11 does the reverse. The step after TOP counts as down, and the step after 0 counts as up.
- R10: In either PWM family, field 01 on channel A is disconnected when select bit 2 is 0 and toggles on every match when it is 1. Field 01 on channel B is always disconnected.
- R11: In a PWM family, when channel A has field bit 1 set and its held compare equals TOP, its matches are ignored. On the TOP tick it takes the level it would take when counting down: 1 for field 10, 0 for field 11.
- R12: In a PWM family, each compare input is copied into its holding register only on an enabled tick taken at TOP. Outside PWM, the holding register follows the input.
- R13: While the count enable is low, the count, direction, waveforms and holding registers keep their values, and no event pulse appears.
- R14: A compare event pulse for a channel rises in the cycle after an enabled tick on which the count equals that channel's effective compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Prescaled count enable (tick) |
| wgm | input | 3 | Waveform select; bit 2 picks TOP from compare A |
| mode_a | input | 2 | Channel A output action field |
| mode_b | input | 2 | Channel B output action field |
| cmp_a | input | 8 | Channel A compare value |
| cmp_b | input | 8 | Channel B compare value |
| port_a | input | 1 | Ordinary port value for pin A |
| port_b | input | 1 | Ordinary port value for pin B |
| dir_a | input | 1 | Direction bit for pin A |
| dir_b | input | 1 | Direction bit for pin B |
| pin_a | output | 1 | Pin A value |
| pin_a_oe | output | 1 | Pin A driver enable |
| pin_b | output | 1 | Pin B value |
| pin_b_oe | output | 1 | Pin B driver enable |
| count | output | 8 | Current count value |
| ovf_evt | output | 1 | Overflow pulse |
| cmpa_evt | output | 1 | Channel A compare pulse |
| cmpb_evt | output | 1 | Channel B compare pulse |

## Verification
The bench moves a compare value in the middle of a PWM period. A design without the holding register would then move the edge of the current period early. It runs channel A with its compare equal to TOP, where a design that did not ignore the match, or that let the match override the TOP action, would produce a stray pulse instead of a constant level. It checks field 01 in each PWM family, which has to toggle only on channel A and only when select bit 2 is set. A decoder that treated the two channels alike, or ignored bit 2, would drive the pin when it should pass the port through. The up/down runs check that the direction changes at both ends. A design that changed direction one step late, or used the stored direction at the turning point, would shift the set and clear edges and the overflow pulse.

// File: rtl/tmr_pkg.sv
// Shared types and decode helpers for the compare waveform timer.
// Assumes a three-bit waveform select whose bit 2 picks TOP from compare A.
package tmr_pkg;

    // Operating family of the counter
    typedef enum logic [1:0] {
        FAM_NORMAL = 2'd0,
        FAM_CTC    = 2'd1,
        FAM_FAST   = 2'd2,
        FAM_PHASE  = 2'd3
    } tmr_fam_e;

    localparam int unsigned NUM_CH = 2;

    // Map the waveform select onto a family; reserved codes run as free count
    function automatic tmr_fam_e tmr_decode(input logic [2:0] sel);
        tmr_fam_e f;
        case (sel)
            3'b001, 3'b101: f = FAM_PHASE;
            3'b011, 3'b111: f = FAM_FAST;
            3'b010:         f = FAM_CTC;
            default:        f = FAM_NORMAL;
        endcase
        return f;
    endfunction

    // True for both PWM families
    function automatic logic tmr_is_pwm(input tmr_fam_e f);
        return (f == FAM_FAST) || (f == FAM_PHASE);
    endfunction

endpackage

// File: rtl/tmr_counter.sv
// Counter core: holds the count and the up/down direction, works out TOP,
// and flags the tick at TOP and the overflow tick. The count only moves on
// cycles where tick is high. Assumes the count stays at or below TOP in the
// PWM families. The overflow pulse is registered, one cycle after its tick.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmr_fam_e     fam,
    input  logic         top_sel,
    input  logic [W-1:0] cmp_a_eff,
    output logic [W-1:0] cnt,
    output logic [W-1:0] top,
    output logic         at_top,
    output logic         next_up,
    output logic         ovf_evt
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic         up;
    logic [W-1:0] cnt_nx;
    logic         ovf_nx;

    // Pick TOP: compare A for clear-on-match or when bit 2 selects it
    always_comb begin
        if (fam == FAM_CTC || (tmr_is_pwm(fam) && top_sel))
            top = cmp_a_eff;
        else
            top = MAXV;
    end

    assign at_top = (cnt == top);

    // Direction of the step the next tick performs
    always_comb begin
        if (fam == FAM_PHASE) begin
            if (at_top)
                next_up = 1'b0;
            else if (cnt == '0)
                next_up = 1'b1;
            else
                next_up = up;
        end else begin
            next_up = 1'b1;
        end
    end

    // Next count and overflow condition for each family
    always_comb begin
        cnt_nx = cnt + 1'b1;
        ovf_nx = 1'b0;
        unique case (fam)
            FAM_NORMAL: begin
                ovf_nx = (cnt == MAXV);
            end
            FAM_CTC: begin
                if (at_top) cnt_nx = '0;
                ovf_nx = (cnt == MAXV);
            end
            FAM_FAST: begin
                if (at_top) cnt_nx = '0;
                ovf_nx = at_top;
            end
            FAM_PHASE: begin
                if (top == '0)
                    cnt_nx = '0;
                else if (!next_up)
                    cnt_nx = cnt - 1'b1;
                ovf_nx = (cnt == '0) && !up;
            end
        endcase
    end

    // Count, direction and overflow pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            up      <= 1'b1;
            ovf_evt <= 1'b0;
        end else begin
            ovf_evt <= tick && ovf_nx;
            if (tick) begin
                cnt <= cnt_nx;
                up  <= next_up;
            end
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && !ovf_evt)); // R13
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fam == FAM_NORMAL && cnt == MAXV) |=> (cnt == '0 && ovf_evt)); // R3
    AST_FAST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fam == FAM_FAST && at_top) |=> (cnt == '0 && ovf_evt)); // R6
    AST_PHASE_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fam == FAM_PHASE && up && at_top && top != '0)
        |=> (cnt == $past(top) - 1'b1 && !up)); // R8

endmodule

// File: rtl/tmr_cmp_buf.sv
// Compare holding register for one channel. In the PWM families it takes
// the compare input only on a tick taken at TOP. Otherwise it follows the
// input each cycle and the effective value is the input itself, so a write
// acts on the very next tick.
module tmr_cmp_buf #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         pwm,
    input  logic         at_top,
    input  logic [W-1:0] cmp_in,
    output logic [W-1:0] eff
);

    logic [W-1:0] held;

    // Reload the held copy outside PWM or at the TOP tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (!pwm || (tick && at_top))
            held <= cmp_in;
    end

    assign eff = pwm ? held : cmp_in;

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !(tick && at_top)) |=> $stable(held)); // R12

endmodule

// File: rtl/tmr_wave_ch.sv
// Output stage for one compare channel. It updates the waveform level from
// the action field, the family, the TOP tick and the step direction, then
// chooses between the waveform and the port value for the pin. IS_A enables
// the channel A rules: toggle in PWM when bit 2 of the select is set, and
// ignore the match when the held compare equals TOP.
module tmr_wave_ch
    import tmr_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter bit          IS_A = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmr_fam_e     fam,
    input  logic         top_sel,
    input  logic [1:0]   mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] top,
    input  logic         at_top,
    input  logic         next_up,
    input  logic [W-1:0] eff,
    input  logic         port,
    input  logic         dir,
    output logic         pin,
    output logic         pin_oe,
    output logic         cmp_evt
);

    logic wave, wave_nx;
    logic match, pwm, tog_ok, special, conn;

    assign pwm     = tmr_is_pwm(fam);
    assign match   = tick && (cnt == eff);
    assign tog_ok  = IS_A && top_sel;
    assign special = IS_A && pwm && mode[1] && (eff == top);
    assign conn    = (mode != 2'b00) && !(pwm && mode == 2'b01 && !tog_ok);

    // Next waveform level from the family and the action field
    always_comb begin
        wave_nx = wave;
        unique case (fam)
            FAM_NORMAL, FAM_CTC: begin
                if (match) begin
                    case (mode)
                        2'b01:   wave_nx = !wave;
                        2'b10:   wave_nx = 1'b0;
                        2'b11:   wave_nx = 1'b1;
                        default: wave_nx = wave;
                    endcase
                end
            end
            FAM_FAST: begin
                if (mode == 2'b01) begin
                    if (tog_ok && match) wave_nx = !wave;
                end else if (mode[1]) begin
                    if (tick && at_top)
                        wave_nx = !mode[0];
                    else if (match && !special)
                        wave_nx = mode[0];
                end
            end
            FAM_PHASE: begin
                if (mode == 2'b01) begin
                    if (tog_ok && match) wave_nx = !wave;
                end else if (mode[1]) begin
                    if (special) begin
                        if (tick && at_top) wave_nx = !mode[0];
                    end else if (match) begin
                        wave_nx = next_up ? mode[0] : !mode[0];
                    end
                end
            end
        endcase
    end

    // Waveform level and compare pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave    <= 1'b0;
            cmp_evt <= 1'b0;
        end else begin
            wave    <= wave_nx;
            cmp_evt <= match;
        end
    end

    assign pin    = conn ? wave : port;
    assign pin_oe = dir;

    AST_FAST_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fam == FAM_FAST && mode[1] && at_top) |=> (wave == !$past(mode[0]))); // R7
    AST_NONPWM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !pwm && mode == 2'b11) |=> wave); // R5
    AST_NONPWM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !pwm && mode == 2'b10) |=> !wave); // R5
    AST_WAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(wave) && !cmp_evt)); // R13

endmodule

// File: rtl/tmr_cmp_wavegen.sv
// Top of the compare waveform timer. It contains one counter core and, per
// channel, a compare holding register and an output stage. Channel A's
// effective compare sets TOP where the waveform select asks for it.
// Assumes cnt_en is already a prescaled single-cycle strobe.
module tmr_cmp_wavegen
    import tmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic [2:0]   wgm,
    input  logic [1:0]   mode_a,
    input  logic [1:0]   mode_b,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         port_a,
    input  logic         port_b,
    input  logic         dir_a,
    input  logic         dir_b,
    output logic         pin_a,
    output logic         pin_a_oe,
    output logic         pin_b,
    output logic         pin_b_oe,
    output logic [W-1:0] count,
    output logic         ovf_evt,
    output logic         cmpa_evt,
    output logic         cmpb_evt
);

    tmr_fam_e     fam;
    logic         top_sel;
    logic [W-1:0] top;
    logic         at_top, next_up;

    logic [1:0]   mode_v [NUM_CH];
    logic [W-1:0] cmp_v  [NUM_CH];
    logic [W-1:0] eff_v  [NUM_CH];
    logic         port_v [NUM_CH];
    logic         dir_v  [NUM_CH];
    logic         pin_v  [NUM_CH];
    logic         oe_v   [NUM_CH];
    logic         evt_v  [NUM_CH];

    assign fam     = tmr_decode(wgm);
    assign top_sel = wgm[2];

    assign mode_v[0] = mode_a;  assign mode_v[1] = mode_b;
    assign cmp_v[0]  = cmp_a;   assign cmp_v[1]  = cmp_b;
    assign port_v[0] = port_a;  assign port_v[1] = port_b;
    assign dir_v[0]  = dir_a;   assign dir_v[1]  = dir_b;

    tmr_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_en),
        .fam       (fam),
        .top_sel   (top_sel),
        .cmp_a_eff (eff_v[0]),
        .cnt       (count),
        .top       (top),
        .at_top    (at_top),
        .next_up   (next_up),
        .ovf_evt   (ovf_evt)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        tmr_cmp_buf #(.W(W)) u_buf (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (cnt_en),
            .pwm    (tmr_is_pwm(fam)),
            .at_top (at_top),
            .cmp_in (cmp_v[ch]),
            .eff    (eff_v[ch])
        );

        tmr_wave_ch #(.W(W), .IS_A(ch == 0)) u_wave (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (cnt_en),
            .fam     (fam),
            .top_sel (top_sel),
            .mode    (mode_v[ch]),
            .cnt     (count),
            .top     (top),
            .at_top  (at_top),
            .next_up (next_up),
            .eff     (eff_v[ch]),
            .port    (port_v[ch]),
            .dir     (dir_v[ch]),
            .pin     (pin_v[ch]),
            .pin_oe  (oe_v[ch]),
            .cmp_evt (evt_v[ch])
        );
    end

    assign pin_a    = pin_v[0];
    assign pin_b    = pin_v[1];
    assign pin_a_oe = oe_v[0];
    assign pin_b_oe = oe_v[1];
    assign cmpa_evt = evt_v[0];
    assign cmpb_evt = evt_v[1];

    AST_EVT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt || cmpa_evt || cmpb_evt) |-> $past(cnt_en)); // R14

endmodule

// File: tb/tmr_cmp_wavegen_test.sv
`timescale 1ns/1ps
module tmr_cmp_wavegen_test;

    typedef struct {
        logic [7:0] cnt;
        logic ovf, ea, eb, pa, pb, oa, ob;
        string tc, tp;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b0;
    logic [2:0] wgm = 3'b000;
    logic [1:0] mode_a = 2'b00, mode_b = 2'b00;
    logic [7:0] cmp_a = 8'd0, cmp_b = 8'd0;
    logic port_a = 1'b1, port_b = 1'b0, dir_a = 1'b0, dir_b = 1'b0;
    logic pin_a, pin_a_oe, pin_b, pin_b_oe, ovf_evt, cmpa_evt, cmpb_evt;
    logic [7:0] count;

    int checks = 0, errors = 0;
    bit done = 0;
    exp_t q[$];
    string tag_c = "R3", tag_p = "R2";

    // reference model state
    logic [7:0] m_cnt, m_buf_a, m_buf_b;
    logic m_up, m_wa, m_wb;

    always #4 clk = ~clk;

    tmr_cmp_wavegen uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wgm(wgm),
        .mode_a(mode_a), .mode_b(mode_b), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .port_a(port_a), .port_b(port_b), .dir_a(dir_a), .dir_b(dir_b),
        .pin_a(pin_a), .pin_a_oe(pin_a_oe), .pin_b(pin_b), .pin_b_oe(pin_b_oe),
        .count(count), .ovf_evt(ovf_evt), .cmpa_evt(cmpa_evt), .cmpb_evt(cmpb_evt)
    );

    task automatic chk(input string req, input string what, input int got, input int expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, expv, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // family: 0 free, 1 clear-on-match, 2 single-slope, 3 up/down
    function automatic int fam_of(input logic [2:0] s);
        if (s == 3'b001 || s == 3'b101) return 3;
        if (s == 3'b011 || s == 3'b111) return 2;
        if (s == 3'b010) return 1;
        return 0;
    endfunction

    function automatic logic wave_step(input bit is_a, input logic [1:0] md, input logic w,
                                       input bit mt, input int f, input bit b2,
                                       input bit attop, input bit nu, input bit eqtop);
        if (f < 2) begin
            if (!mt) return w;
            if (md == 2'd1) return !w;
            if (md == 2'd2) return 1'b0;
            if (md == 2'd3) return 1'b1;
            return w;
        end
        if (md == 2'd0) return w;
        if (md == 2'd1) return (is_a && b2 && mt) ? !w : w;
        if (f == 2) begin
            if (attop) return (md == 2'd2);
            if (mt) return (md == 2'd3);
            return w;
        end
        if (is_a && eqtop) return attop ? (md == 2'd2) : w;
        if (mt) return nu ? (md == 2'd3) : (md == 2'd2);
        return w;
    endfunction

    function automatic bit connected(input bit is_a, input logic [1:0] md, input int f, input bit b2);
        if (md == 2'd0) return 0;
        if (f >= 2 && md == 2'd1 && !(is_a && b2)) return 0;
        return 1;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_up = 1; m_wa = 0; m_wb = 0; m_buf_a = 0; m_buf_b = 0;
    endtask

    task automatic model_step(input bit tk, output exp_t e);
        int f;
        bit pwm, attop, nu, ovf, ma, mb;
        logic [7:0] ea, eb, top, nc;
        f = fam_of(wgm);
        pwm = (f >= 2);
        ea = pwm ? m_buf_a : cmp_a;
        eb = pwm ? m_buf_b : cmp_b;
        top = (f == 1 || (pwm && wgm[2])) ? ea : 8'd255;
        attop = (m_cnt == top);
        nu = 1;
        if (f == 3) nu = attop ? 1'b0 : ((m_cnt == 0) ? 1'b1 : m_up);
        case (f)
            0: begin nc = m_cnt + 8'd1; ovf = (m_cnt == 255); end
            1: begin nc = attop ? 8'd0 : m_cnt + 8'd1; ovf = (m_cnt == 255); end
            2: begin nc = attop ? 8'd0 : m_cnt + 8'd1; ovf = attop; end
            default: begin
                nc = (top == 0) ? 8'd0 : (nu ? m_cnt + 8'd1 : m_cnt - 8'd1);
                ovf = (m_cnt == 0) && !m_up;
            end
        endcase
        ma = tk && (m_cnt == ea);
        mb = tk && (m_cnt == eb);
        e.ovf = tk && ovf;
        e.ea = ma;
        e.eb = mb;
        if (tk) begin
            m_wa = wave_step(1, mode_a, m_wa, ma, f, wgm[2], attop, nu, ea == top);
            m_wb = wave_step(0, mode_b, m_wb, mb, f, wgm[2], attop, nu, eb == top);
            m_cnt = nc;
            m_up = nu;
        end
        if (!pwm || (tk && attop)) begin
            m_buf_a = cmp_a;
            m_buf_b = cmp_b;
        end
        e.cnt = m_cnt;
        e.pa = connected(1, mode_a, f, wgm[2]) ? m_wa : port_a;
        e.pb = connected(0, mode_b, f, wgm[2]) ? m_wb : port_b;
        e.oa = dir_a;
        e.ob = dir_b;
        e.tc = tag_c;
        e.tp = tag_p;
    endtask

    // driver: one model step per cycle, pushed to the scoreboard
    task automatic cyc(input bit tk);
        exp_t e;
        cnt_en = tk;
        model_step(tk, e);
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic run(input int n, input int gap);
        for (int i = 0; i < n; i++) cyc(gap == 0 ? 1'b1 : (i % gap == 0));
    endtask

    task automatic do_reset();
        rst_n = 0;
        cnt_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    // monitor: pops expected items and compares away from the edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(e.tc, "count", count, e.cnt);
                chk(e.tc, "ovf_evt", ovf_evt, e.ovf);
                chk(e.tp, "pin_a", pin_a, e.pa);
                chk(e.tp, "pin_b", pin_b, e.pb);
                chk("R2", "pin_a_oe", pin_a_oe, e.oa);
                chk("R2", "pin_b_oe", pin_b_oe, e.ob);
                chk("R14", "cmpa_evt", cmpa_evt, e.ea);
                chk("R14", "cmpb_evt", cmpb_evt, e.eb);
            end
        end
    end

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: state right after reset
        chk("R1", "count", count, 0);
        chk("R1", "pin_a", pin_a, 1);
        chk("R1", "pin_b", pin_b, 0);
        chk("R1", "ovf_evt", ovf_evt, 0);
        chk("R1", "cmpa_evt", cmpa_evt, 0);
        chk("R1", "cmpb_evt", cmpb_evt, 0);

        // R2: disconnected pins carry port values, enables follow direction
        tag_c = "R3"; tag_p = "R2";
        dir_a = 1; run(10, 0);
        port_a = 0; port_b = 1; dir_a = 0; dir_b = 1; run(10, 0);

        // R3 and R5: free count with toggle and set, then clear
        dir_a = 1; tag_p = "R5";
        cmp_a = 8'd5; mode_a = 2'b01; cmp_b = 8'd10; mode_b = 2'b11;
        run(300, 0);
        mode_b = 2'b10; run(260, 0);
        tag_c = "R13"; tag_p = "R13"; run(40, 3);
        wgm = 3'b110; tag_c = "R3"; tag_p = "R5"; run(40, 0);

        // R4: clear on compare A, immediate compare writes
        do_reset();
        wgm = 3'b010; tag_c = "R4"; tag_p = "R5";
        cmp_a = 8'd20; mode_a = 2'b01; cmp_b = 8'd7; mode_b = 2'b11;
        run(60, 0);
        cmp_a = 8'd9; mode_b = 2'b10; run(40, 0);

        // R6 and R7: single-slope PWM at full range
        do_reset();
        wgm = 3'b011; tag_c = "R6"; tag_p = "R7";
        cmp_a = 8'd100; mode_a = 2'b10; cmp_b = 8'd200; mode_b = 2'b11;
        run(600, 0);
        // R12: compare moved mid period takes effect at TOP
        tag_p = "R12";
        while (m_cnt != 8'd50) cyc(1);
        cmp_a = 8'd20; cmp_b = 8'd30;
        run(600, 0);
        // R10: channel A field 01 with bit 2 clear is disconnected
        tag_p = "R10"; mode_a = 2'b01; port_a = 1; run(300, 0);

        // R6 and R10: TOP from compare A, channel A toggles
        do_reset();
        wgm = 3'b111; tag_c = "R6"; tag_p = "R10";
        cmp_a = 8'd50; mode_a = 2'b01; cmp_b = 8'd20; mode_b = 2'b10;
        run(200, 0);
        // R11: channel A compare equals TOP
        tag_p = "R11"; mode_a = 2'b10; run(200, 0);
        tag_p = "R10"; mode_b = 2'b01; port_b = 0; run(60, 0);

        // R8 and R9: up/down PWM at full range
        do_reset();
        wgm = 3'b001; tag_c = "R8"; tag_p = "R9";
        cmp_a = 8'd60; mode_a = 2'b10; cmp_b = 8'd180; mode_b = 2'b11;
        run(1100, 0);

        // R8, R10, R11: up/down with TOP from compare A
        do_reset();
        wgm = 3'b101; tag_c = "R8"; tag_p = "R10";
        cmp_a = 8'd40; mode_a = 2'b01; cmp_b = 8'd15; mode_b = 2'b01; port_b = 1;
        run(300, 0);
        tag_p = "R11"; mode_a = 2'b11; mode_b = 2'b10; run(300, 0);
        tag_c = "R13"; tag_p = "R13"; run(60, 4);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule